// File: doc/BRIEF.md
# Indirect Program and Lookup-Table Access Window

This block holds two storage arrays for a downstream processing engine and gives a host access to both through four 32-bit registers. The first array holds eight wide program words of 257 bits each. The second is a 2048-byte lookup table. Each array has its own pair of registers. One register of the pair selects the target and the other carries the data.

A program word is too wide for one register. The host therefore picks a slot and a 32-bit chunk within it, and then writes or reads that chunk through the data register. The lookup table is reached through an element index and an element width of 1, 2 or 4 bytes. The block converts these into a byte address and byte lanes. Only the addressed bytes are written, and reads return the element zero-extended.

The engine reads a whole program word by slot number and a whole table word by word address, on separate read ports. Host reads are combinational from `reg_addr`. Host writes take effect on the rising clock edge that samples `reg_wr`.

Top module: `prog_lut_window`

## Requirements
- R1: After reset both select registers read zero, and every bit of the program store reads zero.
- R2: Register map by `reg_addr`: 0 program select, 1 program data, 2 table select, 3 table data.
  - Program select holds the slot in bits [2:0] and the chunk in bits [7:4].
  - Table select holds the index in bits [10:0] and the width code in bits [13:12].
  - Reading either select register returns these fields, with all other bits zero.
- R3: A write to program data replaces chunk c of the selected slot, meaning word bits [32c+31:32c], and nothing else. A read of program data returns that chunk. The engine port shows the full word of the slot on `eng_slot`.
- R4: Chunk 8 holds only word bit 256, in data bit 0. Its upper 31 bits read zero and ignore writes.
- R5: Chunk values 9 to 15 select nothing. Writes to them are ignored and reads return zero.
- R6: Table addressing works as follows:
  - The byte address is the index shifted left by the width code, taken modulo 2048.
  - The word address is the byte address divided by 4.
  - Byte n of a word occupies bits [8n+7:8n].
- R7: Width code 0: a write stores data bits [7:0] into the one addressed byte. A read returns that byte zero-extended.
- R8: Width code 1: a write stores data bits [15:0] into the two addressed bytes, with the lower byte address taking bits [7:0]. A read returns them zero-extended.
- R9: Width code 2: a write replaces the whole addressed word and a read returns it.
- R10: Width code 3 is reserved. Table data writes leave the table unchanged and reads return zero.
- R11: `eng_lut_word` shows the table word at word address `eng_lut_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| eng_slot | input | 3 | Engine program slot select |
| eng_inst | output | 257 | Engine program word |
| eng_lut_addr | input | 9 | Engine table word address |
| eng_lut_word | output | 32 | Engine table word |

## Verification
The assertions check the following on every cycle:
- The padding above bit 256 of a stored program word stays zero.
- An out-of-range chunk reads zero.
- A program write leaves a slot other than the selected one unchanged.
- A single-byte table write alters no other lane of the word.
- A reserved-width write leaves the word unchanged.

Some behaviour only the bench scenarios can show:
- The correct chunk ends up at the correct bit offset.
- Index-to-byte scaling and wraparound land on the intended bytes.
- Zero extension on narrow reads.
- Agreement between host readback and the engine ports across a full sweep of both arrays.

// File: rtl/prog_lut_window.sv
module prog_lut_window #(
  parameter int SLOTS     = 8,
  parameter int INST_W    = 257,
  parameter int LUT_BYTES = 2048,
  parameter int IDX_W     = 11
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic [1:0]                     reg_addr,
  input  logic [31:0]                    reg_wdata,
  output logic [31:0]                    reg_rdata,
  input  logic [$clog2(SLOTS)-1:0]       eng_slot,
  output logic [INST_W-1:0]              eng_inst,
  input  logic [$clog2(LUT_BYTES/4)-1:0] eng_lut_addr,
  output logic [31:0]                    eng_lut_word
);
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int CHUNKS    = (INST_W + 31) / 32;
  localparam int CHK_W     = $clog2(CHUNKS);
  localparam int PAD_W     = CHUNKS * 32;
  localparam int LUT_WORDS = LUT_BYTES / 4;
  localparam int LW_W      = $clog2(LUT_WORDS);
  localparam int BA_W      = $clog2(LUT_BYTES);
  localparam logic [1:0] A_PSEL = 2'd0, A_PDAT = 2'd1, A_LSEL = 2'd2, A_LDAT = 2'd3;
  localparam logic [PAD_W-1:0] VALID = ~({PAD_W{1'b1}} << INST_W);

  logic [SLOT_W-1:0] p_slot;
  logic [CHK_W-1:0]  p_chunk;
  logic [IDX_W-1:0]  l_idx;
  logic [1:0]        l_mode;
  logic [PAD_W-1:0]  prog [SLOTS];
  logic [31:0]       lut  [LUT_WORDS];

  logic              chunk_ok;
  int unsigned       chunk_lo;
  logic [BA_W-1:0]   l_byte;
  logic [LW_W-1:0]   l_word;
  logic [1:0]        l_lane;
  logic [3:0]        be;
  logic [31:0]       lane_data, lut_rd;
  logic              wr_pdat, wr_ldat;

  assign chunk_ok = 32'(p_chunk) < CHUNKS;
  assign chunk_lo = chunk_ok ? 32'(p_chunk) * 32 : 0;
  assign l_byte   = BA_W'(32'(l_idx) << l_mode);
  assign l_word   = l_byte[BA_W-1:2];
  assign l_lane   = l_byte[1:0];
  assign wr_pdat  = reg_wr && reg_addr == A_PDAT && chunk_ok;
  assign wr_ldat  = reg_wr && reg_addr == A_LDAT;

  always_comb begin
    case (l_mode)
      2'd0:    begin be = 4'b0001 << l_lane;                   lane_data = {4{reg_wdata[7:0]}};  end
      2'd1:    begin be = l_lane[1] ? 4'b1100 : 4'b0011;       lane_data = {2{reg_wdata[15:0]}}; end
      2'd2:    begin be = 4'b1111;                             lane_data = reg_wdata;            end
      default: begin be = 4'b0000;                             lane_data = reg_wdata;            end
    endcase
  end

  always_comb begin
    lut_rd = lut[l_word] >> {l_lane, 3'b000};
    case (l_mode)
      2'd0:    lut_rd = lut_rd & 32'h0000_00FF;
      2'd1:    lut_rd = lut_rd & 32'h0000_FFFF;
      2'd2:    lut_rd = lut[l_word];
      default: lut_rd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_slot  <= '0;
      p_chunk <= '0;
      l_idx   <= '0;
      l_mode  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_PSEL) begin
        p_slot  <= reg_wdata[SLOT_W-1:0];
        p_chunk <= reg_wdata[4 +: CHK_W];
      end
      if (reg_addr == A_LSEL) begin
        l_idx  <= reg_wdata[IDX_W-1:0];
        l_mode <= reg_wdata[13:12];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) prog[i] <= '0;
    end else if (wr_pdat) begin
      prog[p_slot][chunk_lo +: 32] <= reg_wdata & VALID[chunk_lo +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ldat)
      for (int b = 0; b < 4; b++)
        if (be[b]) lut[l_word][b*8 +: 8] <= lane_data[b*8 +: 8];
  end

  always_comb begin
    case (reg_addr)
      A_PSEL:  reg_rdata = 32'(p_slot) | (32'(p_chunk) << 4);
      A_PDAT:  reg_rdata = chunk_ok ? prog[p_slot][chunk_lo +: 32] : '0;
      A_LSEL:  reg_rdata = 32'(l_idx) | (32'(l_mode) << 12);
      default: reg_rdata = lut_rd;
    endcase
  end

  assign eng_inst     = prog[eng_slot][INST_W-1:0];
  assign eng_lut_word = lut[eng_lut_addr];

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (prog[eng_slot] & ~VALID) == '0);  // R4

  AST_CHUNK_RANGE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_PDAT && 32'(p_chunk) >= CHUNKS) |-> reg_rdata == '0);  // R5

  AST_OTHER_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pdat && eng_slot != p_slot) |=> (!$stable(eng_slot) || $stable(eng_inst)));  // R3

  AST_BYTE_WRITE_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ldat && l_mode == 2'd0) |=>
      ((lut[$past(l_word)] ^ $past(lut[l_word])) & ~(32'hFF << {$past(l_lane), 3'b000})) == '0);  // R7

  AST_RSVD_WIDTH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ldat && l_mode == 2'd3) |=> lut[$past(l_word)] == $past(lut[l_word]));  // R10
endmodule

// File: tb/tb_prog_lut_window.sv
module tb_prog_lut_window;
  logic         clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0]   reg_addr = 0;
  logic [31:0]  reg_wdata = 0, reg_rdata, eng_lut_word;
  logic [2:0]   eng_slot = 0;
  logic [256:0] eng_inst;
  logic [8:0]   eng_lut_addr = 0;

  prog_lut_window dut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  logic [287:0] m_prog [8];
  logic [7:0]   m_lut  [2048];

  task automatic check(string req, logic [256:0] act, logic [256:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_wr = 0; #1; v = reg_rdata;
  endtask

  function automatic logic [31:0] pat(int s, int c);
    return 32'h9E3779B9 * (s * 16 + c + 1) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [31:0] mword(int w);
    return {m_lut[4*w+3], m_lut[4*w+2], m_lut[4*w+1], m_lut[4*w]};
  endfunction

  task automatic lut_sel(int idx, int mode);
    wr(2'd2, 32'(idx & 11'h7FF) | (32'(mode) << 12));
  endtask

  task automatic lut_put(int idx, int mode, logic [31:0] d);
    int ba;
    lut_sel(idx, mode);
    wr(2'd3, d);
    ba = ((idx & 11'h7FF) << mode) & 2047;
    if (mode < 3)
      for (int k = 0; k < (1 << mode); k++) m_lut[ba + k] = d[8*k +: 8];
  endtask

  task automatic lut_chk(string req, int idx, int mode);
    int ba; logic [31:0] v, e;
    lut_sel(idx, mode);
    rd(2'd3, v);
    ba = ((idx & 11'h7FF) << mode) & 2047;
    e = 0;
    if (mode < 3)
      for (int k = 0; k < (1 << mode); k++) e[8*k +: 8] = m_lut[ba + k];
    check(req, 257'(v), 257'(e));
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int s = 0; s < 8; s++) m_prog[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    rd(2'd0, v); check("R1", 257'(v), 0);
    rd(2'd2, v); check("R1", 257'(v), 0);
    rd(2'd1, v); check("R1", 257'(v), 0);
    for (int s = 0; s < 8; s++) begin
      eng_slot = 3'(s); #1; check("R1", eng_inst, '0);
    end

    // R2: select register fields
    wr(2'd0, 32'hFFFF_FF35); rd(2'd0, v); check("R2", 257'(v), 257'h35);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R2", 257'(v), 257'hF7);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R2", 257'(v), 257'h37FF);

    // R3 R4: sweep all slots and chunks
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 9; c++) begin
        wr(2'd0, 32'(s) | (32'(c) << 4));
        wr(2'd1, pat(s, c));
        m_prog[s][c*32 +: 32] = (c == 8) ? (pat(s, c) & 32'h1) : pat(s, c);
      end
    wr(2'd0, 32'h3 | (32'h2 << 4)); wr(2'd1, 32'hDEAD_BEEF);
    m_prog[3][64 +: 32] = 32'hDEAD_BEEF;
    wr(2'd0, 32'h6 | (32'h8 << 4)); wr(2'd1, 32'hFFFF_FFFF);
    m_prog[6][256 +: 32] = 32'h1;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 9; c++) begin
        wr(2'd0, 32'(s) | (32'(c) << 4));
        rd(2'd1, v);
        check(c == 8 ? "R4" : "R3", 257'(v), 257'(m_prog[s][c*32 +: 32]));
      end
    for (int s = 0; s < 8; s++) begin
      eng_slot = 3'(s); #1; check("R3", eng_inst, m_prog[s][256:0]);
    end

    // R5: chunks 9..15
    for (int c = 9; c < 16; c++) begin
      wr(2'd0, 32'h2 | (32'(c) << 4));
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); check("R5", 257'(v), 0);
    end
    eng_slot = 3'd2; #1; check("R5", eng_inst, m_prog[2][256:0]);

    // R9: fill whole table by words
    for (int w = 0; w < 512; w++) lut_put(w, 2, 32'(w) * 32'h0100_0193 ^ 32'h5A5A_0000);
    for (int w = 0; w < 512; w++) lut_chk("R9", w, 2);
    // R7 R6: byte reads across the table
    for (int b = 0; b < 2048; b++) lut_chk("R7", b, 0);
    // R8 R6: halfword reads
    for (int h = 0; h < 1024; h++) lut_chk("R8", h, 1);

    // R7: byte writes
    lut_put(5, 0, 32'hFFFF_FF11); lut_put(6, 0, 32'h0000_0022); lut_put(2047, 0, 32'hABCD_EF33);
    // R8: halfword writes
    lut_put(3, 1, 32'hFFFF_4455); lut_put(1023, 1, 32'h1234_6677);
    for (int w = 0; w < 512; w++) lut_chk("R7", w, 2);

    // R10: reserved width
    lut_sel(7, 3); wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R10", 257'(v), 0);
    for (int w = 0; w < 512; w++) lut_chk("R10", w, 2);

    // R6: index wraparound
    lut_put(512 + 9, 2, 32'hCAFE_F00D);
    lut_chk("R6", 9, 2);
    lut_put(1024 + 1, 1, 32'h0000_B00C);
    lut_chk("R6", 0, 2);

    // R11: engine table port
    for (int w = 0; w < 512; w++) begin
      eng_lut_addr = 9'(w); #1; check("R11", 257'(eng_lut_word), 257'(mword(w)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule